// File: doc/BRIEF.md
# Twisted-Pair Link Monitor and Port Selector

This block watches the receive side of a twisted-pair Ethernet port and decides whether the link is alive. A receive pulse counts as a link test pulse only when its width, measured in ticks of a 10 MHz timebase, falls inside an accepted window. Frame activity on the receive pair also shows that the link is alive. A link integrity state machine declares the link failed after a long silent interval. It declares the link good again after a run of consecutive valid link pulses, or after any frame activity.

The block reports a polarity status. The output goes low once the receive pair has been seen reversed while the link is good. It stays low after the reversal has been corrected. It goes high whenever the link has failed. The block also picks the active medium, twisted pair or AUI. When automatic selection is on, the choice follows the link state. When it is off, a manual select input sets it. After every port change the selection is held for a settling interval.

Independently of the selected port, the block asks the transmitter for a link test pulse after a set number of ticks of transmit idle. So the twisted-pair side keeps its link pulses going even while AUI is in use.

Top module: `tp_link_port_sel`

## Requirements
- R1: With `autoEn` high, `portTp` moves towards twisted pair (1) while `linkGood` is 1, and towards AUI (0) while it is 0. The change happens one cycle after `linkGood` changes, unless a settling interval is running.
- R2: In the failed state, the link returns to good (`linkGood`=1) after either of two events. One is PASS_PULSES consecutive valid link pulses with no timeout between them. The other is any cycle with `frameAct` high.
- R3: The width of a pulse on `pulseIn` is the number of `tick` cycles seen while `pulseIn` is high. The pulse is valid only if that width is in [LP_MIN_TICKS, LP_MAX_TICKS]. Any other pulse is ignored as activity, and it clears a partial run of consecutive pulses.
- R4: After LINK_FAIL_TICKS ticks with neither a valid pulse nor frame activity, `linkGood` drops to 0.
- R5: `polStatus` goes low once `polRev` has been seen while the link is good.
- R6: `polStatus` stays low after `polRev` deasserts, as long as the link stays good.
- R7: `polStatus` is high whenever `linkGood` is 0. A link failure also clears the stored reversal.
- R8: After `portTp` changes, it holds for SETTLE_TICKS ticks before it may change again.
- R9: `lpReq` is a one-cycle pulse. It is issued after TX_LP_TICKS ticks of transmit idle, whatever the selected port.
- R10: While `txActive` is high, no `lpReq` is issued and the idle interval restarts.
- R11: With `autoEn` low, `portTp` follows `manualSel`, subject to R8, and link status is still reported.
- R12: After reset: `linkGood`=0, `polStatus`=1, `portTp`=0, `lpReq`=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| tick | input | 1 | 10 MHz timebase strobe |
| pulseIn | input | 1 | Sampled receive pulse detect level |
| frameAct | input | 1 | Receive frame activity |
| polRev | input | 1 | Receive pair reversed detect |
| autoEn | input | 1 | Automatic port selection enable |
| manualSel | input | 1 | Manual port choice (1 = twisted pair) |
| txActive | input | 1 | Transmit data in progress |
| linkGood | output | 1 | Link integrity passed |
| polStatus | output | 1 | Low = reversed pair on good link, high = link failed or normal |
| portTp | output | 1 | Selected port, 1 = twisted pair, 0 = AUI |
| lpReq | output | 1 | One-cycle request for a transmit link pulse |

## Verification
Inputs are sampled on a clock edge. `linkGood` and `lpReq` change on that same edge, and `polStatus` follows the link and reversal registers on that edge too. `portTp` trails `linkGood` or `manualSel` by one more edge. A pulse is judged on the edge where `pulseIn` is first seen low, so its effect on `linkGood` appears on that edge. The bench drives inputs 2 ns after a rising edge and compares every output with its reference model on the falling edge, which lines each expected value up with the edge it belongs to.

// File: rtl/lps_pkg.sv
package lps_pkg;
  typedef enum logic {LINK_FAIL = 1'b0, LINK_PASS = 1'b1} linkState_t;

  // control -> datapath strobes
  typedef struct packed {
    logic clrIdle;
    logic clrTx;
    logic settling;
  } ctlStrobes_t;

  // datapath -> control status
  typedef struct packed {
    logic validPulse;
    logic invalidPulse;
    logic idleExpired;
    logic txDue;
    logic settleDone;
  } dpStatus_t;
endpackage

// File: rtl/lps_tick_counter.sv
module lps_tick_counter #(
  parameter int LIMIT = 16
) (
  input  logic clk,
  input  logic rstN,
  input  logic clr,
  input  logic tick,
  output logic done
);
  localparam int CW = $clog2(LIMIT + 1);
  localparam logic [CW-1:0] LIM = CW'(LIMIT);

  logic [CW-1:0] cnt;

  always_ff @(posedge clk) begin
    if (!rstN)                   cnt <= '0;
    else if (clr)                cnt <= '0;
    else if (tick && cnt != LIM) cnt <= cnt + 1'b1;
  end

  assign done = (cnt == LIM);
endmodule

// File: rtl/lps_datapath.sv
module lps_datapath
  import lps_pkg::*;
#(
  parameter int LP_MIN_TICKS    = 1,
  parameter int LP_MAX_TICKS    = 2,
  parameter int LINK_FAIL_TICKS = 1000000,
  parameter int TX_LP_TICKS     = 160000,
  parameter int SETTLE_TICKS    = 10000
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic        tick,
  input  logic        pulseIn,
  input  ctlStrobes_t ctl,
  output dpStatus_t   st
);
  localparam int WW = $clog2(LP_MAX_TICKS + 2);
  localparam logic [WW-1:0] WMIN = WW'(LP_MIN_TICKS);
  localparam logic [WW-1:0] WMAX = WW'(LP_MAX_TICKS);

  logic          pulsePrev;
  logic [WW-1:0] widthCnt;
  logic          pulseEnd;

  // width measured in ticks, saturating one past the accepted maximum
  always_ff @(posedge clk) begin
    if (!rstN) begin
      pulsePrev <= 1'b0;
      widthCnt  <= '0;
    end else begin
      pulsePrev <= pulseIn;
      if (!pulseIn)                    widthCnt <= '0;
      else if (tick && widthCnt <= WMAX) widthCnt <= widthCnt + 1'b1;
    end
  end

  assign pulseEnd        = pulsePrev && !pulseIn;
  assign st.validPulse   = pulseEnd && (widthCnt >= WMIN) && (widthCnt <= WMAX);
  assign st.invalidPulse = pulseEnd && !st.validPulse;

  localparam int NT = 3;
  localparam int LIMITS [NT] = '{LINK_FAIL_TICKS, TX_LP_TICKS, SETTLE_TICKS};
  logic [NT-1:0] clrs;
  logic [NT-1:0] dones;

  assign clrs = {!ctl.settling, ctl.clrTx, ctl.clrIdle};

  for (genvar g = 0; g < NT; g++) begin : g_timer
    lps_tick_counter #(.LIMIT(LIMITS[g])) u_cnt (
      .clk  (clk),
      .rstN (rstN),
      .clr  (clrs[g]),
      .tick (tick),
      .done (dones[g])
    );
  end

  assign st.idleExpired = dones[0];
  assign st.txDue       = dones[1];
  assign st.settleDone  = dones[2];
endmodule

// File: rtl/lps_control.sv
module lps_control
  import lps_pkg::*;
#(
  parameter int PASS_PULSES = 2
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic        frameAct,
  input  logic        polRev,
  input  logic        autoEn,
  input  logic        manualSel,
  input  logic        txActive,
  input  dpStatus_t   st,
  output ctlStrobes_t ctl,
  output logic        linkGood,
  output logic        polStatus,
  output logic        portTp,
  output logic        lpReq
);
  localparam int PW = $clog2(PASS_PULSES + 1);
  localparam logic [PW-1:0] PLAST = PW'(PASS_PULSES - 1);

  linkState_t    linkState;
  logic [PW-1:0] passCnt;
  logic          polFlag;
  logic          settling;
  logic          activity;
  logic          goFail;
  logic          target;

  assign activity = st.validPulse || frameAct;
  assign goFail   = (linkState == LINK_PASS) && st.idleExpired && !activity;
  assign linkGood = (linkState == LINK_PASS);
  assign target   = autoEn ? linkGood : manualSel;

  assign ctl.clrIdle  = activity;
  assign ctl.clrTx    = txActive || st.txDue;
  assign ctl.settling = settling;

  // link integrity state machine
  always_ff @(posedge clk) begin
    if (!rstN) begin
      linkState <= LINK_FAIL;
      passCnt   <= '0;
    end else if (linkState == LINK_PASS) begin
      passCnt <= '0;
      if (goFail) linkState <= LINK_FAIL;
    end else begin
      if (frameAct) begin
        linkState <= LINK_PASS;
        passCnt   <= '0;
      end else if (st.validPulse) begin
        if (passCnt == PLAST) begin
          linkState <= LINK_PASS;
          passCnt   <= '0;
        end else begin
          passCnt <= passCnt + 1'b1;
        end
      end else if (st.invalidPulse || st.idleExpired) begin
        passCnt <= '0;
      end
    end
  end

  // sticky reversal flag, cleared on link failure
  always_ff @(posedge clk) begin
    if (!rstN)       polFlag <= 1'b0;
    else if (goFail) polFlag <= 1'b0;
    else if (polRev) polFlag <= 1'b1;
  end

  assign polStatus = !(linkGood && polFlag);

  // port selection with settling hold
  always_ff @(posedge clk) begin
    if (!rstN) begin
      portTp   <= 1'b0;
      settling <= 1'b0;
    end else if (!settling) begin
      if (target != portTp) begin
        portTp   <= target;
        settling <= 1'b1;
      end
    end else if (st.settleDone) begin
      settling <= 1'b0;
    end
  end

  // transmit link pulse request
  always_ff @(posedge clk) begin
    if (!rstN) lpReq <= 1'b0;
    else       lpReq <= st.txDue && !txActive;
  end
endmodule

// File: rtl/tp_link_port_sel.sv
module tp_link_port_sel
  import lps_pkg::*;
#(
  parameter int LP_MIN_TICKS    = 1,
  parameter int LP_MAX_TICKS    = 2,
  parameter int LINK_FAIL_TICKS = 1000000,
  parameter int PASS_PULSES     = 2,
  parameter int TX_LP_TICKS     = 160000,
  parameter int SETTLE_TICKS    = 10000
) (
  input  logic clk,
  input  logic rstN,
  input  logic tick,
  input  logic pulseIn,
  input  logic frameAct,
  input  logic polRev,
  input  logic autoEn,
  input  logic manualSel,
  input  logic txActive,
  output logic linkGood,
  output logic polStatus,
  output logic portTp,
  output logic lpReq
);
  ctlStrobes_t ctl;
  dpStatus_t   st;

  lps_datapath #(
    .LP_MIN_TICKS    (LP_MIN_TICKS),
    .LP_MAX_TICKS    (LP_MAX_TICKS),
    .LINK_FAIL_TICKS (LINK_FAIL_TICKS),
    .TX_LP_TICKS     (TX_LP_TICKS),
    .SETTLE_TICKS    (SETTLE_TICKS)
  ) u_dp (
    .clk     (clk),
    .rstN    (rstN),
    .tick    (tick),
    .pulseIn (pulseIn),
    .ctl     (ctl),
    .st      (st)
  );

  lps_control #(.PASS_PULSES(PASS_PULSES)) u_ctl (
    .clk       (clk),
    .rstN      (rstN),
    .frameAct  (frameAct),
    .polRev    (polRev),
    .autoEn    (autoEn),
    .manualSel (manualSel),
    .txActive  (txActive),
    .st        (st),
    .ctl       (ctl),
    .linkGood  (linkGood),
    .polStatus (polStatus),
    .portTp    (portTp),
    .lpReq     (lpReq)
  );
endmodule

// File: rtl/tp_link_port_sel_chk.sv
module tp_link_port_sel_chk (
  input logic clk,
  input logic rstN,
  input logic pulseIn,
  input logic frameAct,
  input logic polRev,
  input logic txActive,
  input logic linkGood,
  input logic polStatus,
  input logic portTp,
  input logic lpReq
);
  // R7
  fail_pol_high_chk: assert property (@(posedge clk) disable iff (!rstN)
    !linkGood |-> polStatus);

  // R5
  rev_pol_low_chk: assert property (@(posedge clk) disable iff (!rstN)
    (linkGood && $past(linkGood) && $past(polRev)) |-> !polStatus);

  // R2
  pass_cause_chk: assert property (@(posedge clk) disable iff (!rstN)
    $rose(linkGood) |-> ($past(frameAct) || ($past(pulseIn, 2) && !$past(pulseIn))));

  // R8
  settle_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    !$stable(portTp) |=> $stable(portTp));

  // R9
  req_single_chk: assert property (@(posedge clk) disable iff (!rstN)
    lpReq |=> !lpReq);

  // R10
  req_quiet_chk: assert property (@(posedge clk) disable iff (!rstN)
    lpReq |-> !$past(txActive));
endmodule

bind tp_link_port_sel tp_link_port_sel_chk u_chk (.*);

// File: tb/tb_tp_link_port_sel.sv
module tb_tp_link_port_sel;
  localparam int MINW = 2, MAXW = 3, FAILT = 40, NPASS = 2, TXT = 25, SETT = 10;

  logic clk = 1'b0, rstN = 1'b0, tick = 1'b0;
  logic pulseIn = 0, frameAct = 0, polRev = 0, autoEn = 0, manualSel = 0, txActive = 0;
  logic linkGood, polStatus, portTp, lpReq;

  int nChecks = 0, nFails = 0, cyc = 0, reqCount = 0;
  bit doneFlag = 0;

  always #4 clk = ~clk;

  tp_link_port_sel #(
    .LP_MIN_TICKS(MINW), .LP_MAX_TICKS(MAXW), .LINK_FAIL_TICKS(FAILT),
    .PASS_PULSES(NPASS), .TX_LP_TICKS(TXT), .SETTLE_TICKS(SETT)
  ) dut (.*);

  always @(posedge clk) begin #2; tick = !tick; end

  task automatic check(input string tag, input int act, input int exp);
    nChecks++;
    if (act != exp) begin
      nFails++;
      $display("FAIL %s at cycle %0d: actual %0d expected %0d", tag, cyc, act, exp);
    end
  endtask

  task automatic finishRun();
    $display("%0d/%0d checks passed", nChecks - nFails, nChecks);
    $finish;
  endtask

  // behavioural reference model
  int mW, mIdle, mTx, mSc, mPassCnt;
  bit mPrev, mPass, mPol, mPort, mSettling, mReq;

  always @(posedge clk) begin
    cyc++;
    if (lpReq) reqCount++;
    if (!rstN) begin
      mW = 0; mIdle = 0; mTx = 0; mSc = 0; mPassCnt = 0;
      mPrev = 0; mPass = 0; mPol = 0; mPort = 0; mSettling = 0; mReq = 0;
    end else begin
      bit ended, valid, invalid, act, idleExp, txDue, setDone, tgt, goFail;
      ended   = mPrev && !pulseIn;
      valid   = ended && mW >= MINW && mW <= MAXW;
      invalid = ended && !valid;
      act     = valid || frameAct;
      idleExp = (mIdle == FAILT);
      txDue   = (mTx == TXT);
      setDone = (mSc == SETT);
      tgt     = autoEn ? mPass : manualSel;
      goFail  = mPass && idleExp && !act;
      mPrev = pulseIn;
      if (!pulseIn) mW = 0; else if (tick && mW <= MAXW) mW++;
      if (act) mIdle = 0; else if (tick && mIdle < FAILT) mIdle++;
      if (txActive || txDue) mTx = 0; else if (tick && mTx < TXT) mTx++;
      if (!mSettling) mSc = 0; else if (tick && mSc < SETT) mSc++;
      if (mPass) begin
        mPassCnt = 0;
        if (goFail) mPass = 0;
      end else if (frameAct) begin
        mPass = 1; mPassCnt = 0;
      end else if (valid) begin
        if (mPassCnt == NPASS - 1) begin mPass = 1; mPassCnt = 0; end
        else mPassCnt++;
      end else if (invalid || idleExp) mPassCnt = 0;
      if (goFail) mPol = 0; else if (polRev) mPol = 1;
      if (!mSettling) begin
        if (tgt != mPort) begin mPort = tgt; mSettling = 1; end
      end else if (setDone) mSettling = 0;
      mReq = txDue && !txActive;
    end
  end

  // per-cycle comparison away from the active edge
  always @(negedge clk) begin
    if (rstN && !doneFlag) begin
      check("R4 linkGood", linkGood, mPass);
      check("R5 polStatus", polStatus, !(mPass && mPol));
      check("R1 portTp", portTp, mPort);
      check("R9 lpReq", lpReq, mReq);
    end
  end

  task automatic cycles(input int n);
    repeat (n) @(posedge clk);
    #2;
  endtask

  task automatic pulse(input int hi, input int gap);
    pulseIn = 1; cycles(hi);
    pulseIn = 0; cycles(gap);
  endtask

  initial begin
    cycles(3);
    // R12 reset values
    @(negedge clk);
    check("R12 linkGood", linkGood, 0);
    check("R12 polStatus", polStatus, 1);
    check("R12 portTp", portTp, 0);
    check("R12 lpReq", lpReq, 0);
    @(posedge clk); #2;
    rstN = 1; autoEn = 1;
    cycles(90);
    // R3 too-long and too-short pulses do not bring the link up
    pulse(12, 6); pulse(1, 6); pulse(12, 6); pulse(1, 6);
    @(negedge clk); check("R3 linkGood", linkGood, 0);
    @(posedge clk); #2;
    // R2 two valid pulses restore the link
    pulse(4, 6); pulse(4, 3);
    @(negedge clk); check("R2 linkGood", linkGood, 1);
    @(posedge clk); #2;
    cycles(30);
    @(negedge clk); check("R1 portTp", portTp, 1);
    @(posedge clk); #2;
    // R5 / R6 reversal while pulses keep the link alive
    polRev = 1; cycles(2); polRev = 0;
    pulse(4, 20);
    @(negedge clk); check("R5 polStatus", polStatus, 0);
    @(posedge clk); #2;
    pulse(4, 20); pulse(4, 20);
    @(negedge clk); check("R6 polStatus", polStatus, 0);
    @(posedge clk); #2;
    // R4 / R7 silence fails the link
    cycles(100);
    @(negedge clk);
    check("R4 linkGood", linkGood, 0);
    check("R7 polStatus", polStatus, 1);
    @(posedge clk); #2;
    cycles(30);
    // R9 link pulses requested while AUI is selected
    reqCount = 0; cycles(200);
    @(negedge clk);
    check("R1 portTp AUI", portTp, 0);
    check("R9 requests", int'(reqCount >= 3), 1);
    @(posedge clk); #2;
    // R10 transmit activity suppresses requests
    txActive = 1; reqCount = 0; cycles(200);
    @(negedge clk); check("R10 requests", reqCount, 0);
    @(posedge clk); #2;
    txActive = 0;
    // R2 frame activity alone restores the link
    frameAct = 1; cycles(1); frameAct = 0;
    @(negedge clk); check("R2 frame linkGood", linkGood, 1);
    @(posedge clk); #2;
    cycles(40);
    // R11 / R8 manual selection with settling hold
    autoEn = 0; manualSel = 0; cycles(2);
    @(negedge clk); check("R11 portTp", portTp, 0);
    @(posedge clk); #2;
    cycles(30);
    manualSel = 1; cycles(2);
    manualSel = 0; cycles(3);
    @(negedge clk); check("R8 portTp held", portTp, 1);
    @(posedge clk); #2;
    cycles(40);
    @(negedge clk); check("R11 portTp", portTp, 0);
    doneFlag = 1;
    finishRun();
  end

  initial begin
    repeat (20000) @(posedge clk);
    doneFlag = 1;
    nChecks++; nFails++;
    $display("FAIL watchdog: actual timeout expected completion");
    finishRun();
  end
endmodule